// File: doc/BRIEF.md
# Single-Level Page-Table Address Translator

This block turns 32-bit device virtual addresses into bus physical addresses. Each 4 KB virtual page has one 32-bit descriptor in a flat table held in memory. The table is found from a base page number. A request comes in with an address and a read/write flag. The block first searches an eight-slot, fully associative translation cache. On a miss it reads the descriptor through a simple memory read port, checks it, caches it when it is valid, and answers with the translated address and fault indications.

Fault handling is chosen separately for two classes: a descriptor that is not valid, and a write through a descriptor that is not writeable. An enabled class marks the response as a fault. It can also abort the access, raise a level interrupt, or send the access to a scratch page. The first enabled fault is kept in a sticky record until software clears it. A cache-flush command runs by itself over several cycles and shows a busy flag while it runs. When translation is switched off, addresses pass straight through.

Top module: `ptmmu_top`

## Requirements
- R1: With `cfg_enable` at 0, a request is answered on the cycle after it is accepted. `rsp_paddr` is the virtual address zero-extended, fault and abort stay low, and no table read is made.
- R2: On a cache miss, exactly one table read is issued, at address `{cfg_pt_base, 12'b0} + vpn*4`, where vpn is the virtual address bits 31:12. The response comes on the cycle after `mem_rd_ack`. Descriptor fields: bit 28 valid, bit 29 writeable, bit 31 superpage, bits 23:0 physical page number. The output address is `{ppn, vaddr[11:0]}`.
- R3: Valid descriptors are cached. A repeated page is answered on the cycle after acceptance, with no table read.
- R4: The eight cache slots are filled in rotating order. After eight further distinct fills, the first-filled page misses again. A flush does not reset the rotation.
- R5: A descriptor with bit 31 set covers the whole 1 MB region sharing vaddr bits 31:20, and any page in that region hits it. The output page number is `{ppn[23:8], vaddr[19:12]}`.
- R6: An invalid descriptor with `cfg_inv_en` set gives `rsp_fault`=1. With `cfg_inv_abort` also set, it gives `rsp_abort`=1 and `rsp_paddr`=0. Invalid descriptors are never cached. With `cfg_inv_en` clear, no fault is raised and the descriptor's page number is used.
- R7: A write through a valid descriptor whose writeable bit is 0, with `cfg_wv_en` set, is a write-violation fault. Reads through the same descriptor do not fault. `cfg_wv_abort` aborts the access as in R6.
- R8: An enabled fault that is not aborted goes to `{cfg_scratch_ppn, vaddr[11:0]}` when `cfg_scratch_en` is 1. Otherwise it uses the descriptor's page number.
- R9: The first enabled fault sets `fault_valid` and latches `fault_vaddr` and `fault_type`, where bit 0 means invalid and bit 1 means write violation. Later faults do not overwrite the record until a `fault_clr` pulse.
- R10: `irq` rises together with the response of an enabled fault whose class interrupt bit is set, and stays high until `fault_clr`. Faults whose class interrupt bit is clear leave `irq` low.
- R11: A `tlb_clear` pulse makes `tlb_clearing` read 1 from the next cycle for 9 cycles (slots + 1). No request is accepted during that time, and afterwards every page misses. Further pulses while it reads 1 are ignored and do not lengthen it.
- R12: Only one table read is outstanding at a time: `req_ready` stays low from the acceptance of a miss until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 36 | Translated physical address |
| rsp_fault | output | 1 | Enabled fault occurred |
| rsp_abort | output | 1 | Access aborted |
| mem_rd_req | output | 1 | Table read request, held until ack |
| mem_rd_addr | output | 36 | Table read byte address |
| mem_rd_ack | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Descriptor read from table |
| cfg_enable | input | 1 | Translation enable |
| cfg_pt_base | input | 24 | Table base page number |
| cfg_inv_en | input | 1 | Invalid-descriptor fault enable |
| cfg_inv_abort | input | 1 | Abort on invalid descriptor |
| cfg_inv_irq | input | 1 | Interrupt on invalid descriptor |
| cfg_wv_en | input | 1 | Write-violation fault enable |
| cfg_wv_abort | input | 1 | Abort on write violation |
| cfg_wv_irq | input | 1 | Interrupt on write violation |
| cfg_scratch_en | input | 1 | Redirect non-aborted faults |
| cfg_scratch_ppn | input | 24 | Scratch page number |
| tlb_clear | input | 1 | Start cache flush |
| tlb_clearing | output | 1 | Flush in progress |
| fault_valid | output | 1 | Sticky fault record present |
| fault_vaddr | output | 32 | Recorded faulting address |
| fault_type | output | 2 | Recorded fault class |
| fault_clr | input | 1 | Write-one-to-clear of record and irq |
| irq | output | 1 | Level fault interrupt |

## Verification
The hardest state to reach from the ports is a full cache whose oldest slot is about to be replaced. Reaching it takes nine distinct valid misses with no flush in between, and hits must not disturb the rotation. The directed part flushes the cache and then walks nine consecutive valid pages. It then probes both the evicted page and a surviving page. The random part draws from a small pool of pages so that hits, misses, superpage reuse and overlapping faults pile up against a bench-side model of cache contents and sticky state.

// File: rtl/ptmmu_pkg.sv
package ptmmu_pkg;
    localparam int ENT_W         = 32;
    localparam int ENT_VALID_BIT = 28;
    localparam int ENT_WR_BIT    = 29;
    localparam int ENT_SUPER_BIT = 31;

    // fault_type bit positions
    localparam int FT_INVALID = 0;
    localparam int FT_WRVIOL  = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CLEAR = 2'd2
    } walk_st_e;
endpackage

// File: rtl/ptmmu_tlb.sv
module ptmmu_tlb #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 24,
    parameter int N     = 8,
    parameter int SUP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [VPN_W-1:0]         lk_vpn,
    output logic                     lk_hit,
    output logic [PPN_W-1:0]         lk_ppn,
    output logic                     lk_wr,
    output logic                     lk_sup,
    input  logic                     fill_en,
    input  logic [VPN_W-1:0]         fill_vpn,
    input  logic [PPN_W-1:0]         fill_ppn,
    input  logic                     fill_wr,
    input  logic                     fill_sup,
    input  logic                     inv_en,
    input  logic [$clog2(N)-1:0]     inv_idx
);
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic             vld;
        logic             sup;
        logic             wr;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } slot_t;

    typedef struct packed {
        slot_t [N-1:0]    slot;
        logic [IDX_W-1:0] rr;
    } tlb_state_t;

    tlb_state_t state_d, state_q;
    logic [N-1:0] hit_vec;

    // per-slot match: superpages compare only the region bits
    for (genvar g = 0; g < N; g++) begin : g_match
        assign hit_vec[g] = state_q.slot[g].vld &&
            (state_q.slot[g].sup
                ? (state_q.slot[g].tag[VPN_W-1:SUP_W] == lk_vpn[VPN_W-1:SUP_W])
                : (state_q.slot[g].tag == lk_vpn));
    end

    always_comb begin
        lk_ppn = '0;
        lk_wr  = 1'b0;
        lk_sup = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                lk_ppn = lk_ppn | state_q.slot[i].ppn;
                lk_wr  = lk_wr  | state_q.slot[i].wr;
                lk_sup = lk_sup | state_q.slot[i].sup;
            end
        end
    end
    assign lk_hit = |hit_vec;

    always_comb begin
        state_d = state_q;
        if (inv_en) begin
            state_d.slot[inv_idx].vld = 1'b0;
        end
        if (fill_en) begin
            state_d.slot[state_q.rr].vld = 1'b1;
            state_d.slot[state_q.rr].sup = fill_sup;
            state_d.slot[state_q.rr].wr  = fill_wr;
            state_d.slot[state_q.rr].tag = fill_vpn;
            state_d.slot[state_q.rr].ppn = fill_ppn;
            state_d.rr = (state_q.rr == IDX_W'(N-1)) ? '0 : state_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R3: a page never matches two cached slots
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/ptmmu_fault_eval.sv
module ptmmu_fault_eval #(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int PPN_W      = 24
) (
    input  logic                        xl_en,
    input  logic [VA_W-1:0]             va,
    input  logic                        is_wr,
    input  logic                        ent_valid,
    input  logic                        ent_wr,
    input  logic [PPN_W-1:0]            eff_ppn,
    input  logic                        inv_en,
    input  logic                        inv_abort,
    input  logic                        inv_irq,
    input  logic                        wv_en,
    input  logic                        wv_abort,
    input  logic                        wv_irq,
    input  logic                        scratch_en,
    input  logic [PPN_W-1:0]            scratch_ppn,
    output logic [PPN_W+PAGE_SHIFT-1:0] pa,
    output logic                        fault,
    output logic                        abort,
    output logic [1:0]                  ftype,
    output logic                        raise_irq
);
    import ptmmu_pkg::*;
    localparam int PA_W = PPN_W + PAGE_SHIFT;

    logic                  is_inv, is_wv;
    logic [PAGE_SHIFT-1:0] off;

    always_comb begin
        off       = va[PAGE_SHIFT-1:0];
        is_inv    = !ent_valid;
        is_wv     = ent_valid && is_wr && !ent_wr;
        fault     = 1'b0;
        abort     = 1'b0;
        ftype     = '0;
        raise_irq = 1'b0;
        if (xl_en) begin
            if (is_inv && inv_en) begin
                fault             = 1'b1;
                abort             = inv_abort;
                ftype[FT_INVALID] = 1'b1;
                raise_irq         = inv_irq;
            end else if (is_wv && wv_en) begin
                fault            = 1'b1;
                abort            = wv_abort;
                ftype[FT_WRVIOL] = 1'b1;
                raise_irq        = wv_irq;
            end
        end
        if (!xl_en)                    pa = PA_W'(va);
        else if (abort)                pa = '0;
        else if (fault && scratch_en)  pa = {scratch_ppn, off};
        else                           pa = {eff_ppn, off};
    end
endmodule

// File: rtl/ptmmu_top.sv
module ptmmu_top #(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int PPN_W      = 24,
    parameter int TLB_N      = 8,
    parameter int SUP_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [VA_W-1:0]             req_vaddr,
    input  logic                        req_write,
    output logic                        rsp_valid,
    output logic [PPN_W+PAGE_SHIFT-1:0] rsp_paddr,
    output logic                        rsp_fault,
    output logic                        rsp_abort,
    output logic                        mem_rd_req,
    output logic [PPN_W+PAGE_SHIFT-1:0] mem_rd_addr,
    input  logic                        mem_rd_ack,
    input  logic [31:0]                 mem_rd_data,
    input  logic                        cfg_enable,
    input  logic [PPN_W-1:0]            cfg_pt_base,
    input  logic                        cfg_inv_en,
    input  logic                        cfg_inv_abort,
    input  logic                        cfg_inv_irq,
    input  logic                        cfg_wv_en,
    input  logic                        cfg_wv_abort,
    input  logic                        cfg_wv_irq,
    input  logic                        cfg_scratch_en,
    input  logic [PPN_W-1:0]            cfg_scratch_ppn,
    input  logic                        tlb_clear,
    output logic                        tlb_clearing,
    output logic                        fault_valid,
    output logic [VA_W-1:0]             fault_vaddr,
    output logic [1:0]                  fault_type,
    input  logic                        fault_clr,
    output logic                        irq
);
    import ptmmu_pkg::*;

    localparam int VPN_W = VA_W - PAGE_SHIFT;
    localparam int PA_W  = PPN_W + PAGE_SHIFT;
    localparam int IDX_W = $clog2(TLB_N);

    typedef struct packed {
        walk_st_e         st;
        logic             clr_pend;
        logic [IDX_W-1:0] clr_idx;
        logic [VA_W-1:0]  pend_va;
        logic             pend_wr;
        logic             rsp_v;
        logic [PA_W-1:0]  rsp_pa;
        logic             rsp_fault;
        logic             rsp_abort;
        logic             flt_v;
        logic [VA_W-1:0]  flt_va;
        logic [1:0]       flt_ty;
        logic             irq;
    } top_state_t;

    top_state_t state_d, state_q;

    logic             accept, fetch_done, do_rsp;
    logic             lk_hit, lk_wr, lk_sup;
    logic [PPN_W-1:0] lk_ppn;
    logic             fill_en, inv_en;
    logic [VA_W-1:0]  sel_va;
    logic             sel_wr, sel_valid, sel_entwr, sel_sup;
    logic [PPN_W-1:0] sel_ppn, eff_ppn;
    logic [PA_W-1:0]  ev_pa;
    logic             ev_fault, ev_abort, ev_irq;
    logic [1:0]       ev_type;
    logic             unused_bits;

    assign unused_bits  = ^{mem_rd_data[30], mem_rd_data[27:PPN_W]};

    assign tlb_clearing = state_q.clr_pend || (state_q.st == ST_CLEAR);
    assign req_ready    = (state_q.st == ST_IDLE) && !tlb_clearing;
    assign accept       = req_valid && req_ready;
    assign fetch_done   = (state_q.st == ST_FETCH) && mem_rd_ack;
    assign do_rsp       = (accept && (!cfg_enable || lk_hit)) || fetch_done;

    assign mem_rd_req  = (state_q.st == ST_FETCH);
    assign mem_rd_addr = {cfg_pt_base, {PAGE_SHIFT{1'b0}}}
                       + PA_W'({state_q.pend_va[VA_W-1:PAGE_SHIFT], 2'b00});

    // choose the descriptor source: fresh table read or cached slot
    always_comb begin
        if (fetch_done) begin
            sel_va    = state_q.pend_va;
            sel_wr    = state_q.pend_wr;
            sel_valid = mem_rd_data[ENT_VALID_BIT];
            sel_entwr = mem_rd_data[ENT_WR_BIT];
            sel_sup   = mem_rd_data[ENT_SUPER_BIT];
            sel_ppn   = mem_rd_data[PPN_W-1:0];
        end else begin
            sel_va    = req_vaddr;
            sel_wr    = req_write;
            sel_valid = 1'b1;
            sel_entwr = lk_wr;
            sel_sup   = lk_sup;
            sel_ppn   = lk_ppn;
        end
        eff_ppn = sel_sup
            ? {sel_ppn[PPN_W-1:SUP_W], sel_va[PAGE_SHIFT+SUP_W-1:PAGE_SHIFT]}
            : sel_ppn;
    end

    assign fill_en = fetch_done && cfg_enable && sel_valid;
    assign inv_en  = (state_q.st == ST_CLEAR);

    ptmmu_tlb #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .N(TLB_N), .SUP_W(SUP_W)
    ) tlb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_vaddr[VA_W-1:PAGE_SHIFT]),
        .lk_hit   (lk_hit),
        .lk_ppn   (lk_ppn),
        .lk_wr    (lk_wr),
        .lk_sup   (lk_sup),
        .fill_en  (fill_en),
        .fill_vpn (state_q.pend_va[VA_W-1:PAGE_SHIFT]),
        .fill_ppn (sel_ppn),
        .fill_wr  (sel_entwr),
        .fill_sup (sel_sup),
        .inv_en   (inv_en),
        .inv_idx  (state_q.clr_idx)
    );

    ptmmu_fault_eval #(
        .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .PPN_W(PPN_W)
    ) eval_i (
        .xl_en       (cfg_enable),
        .va          (sel_va),
        .is_wr       (sel_wr),
        .ent_valid   (sel_valid),
        .ent_wr      (sel_entwr),
        .eff_ppn     (eff_ppn),
        .inv_en      (cfg_inv_en),
        .inv_abort   (cfg_inv_abort),
        .inv_irq     (cfg_inv_irq),
        .wv_en       (cfg_wv_en),
        .wv_abort    (cfg_wv_abort),
        .wv_irq      (cfg_wv_irq),
        .scratch_en  (cfg_scratch_en),
        .scratch_ppn (cfg_scratch_ppn),
        .pa          (ev_pa),
        .fault       (ev_fault),
        .abort       (ev_abort),
        .ftype       (ev_type),
        .raise_irq   (ev_irq)
    );

    always_comb begin
        state_d       = state_q;
        state_d.rsp_v = 1'b0;

        if (tlb_clear && !tlb_clearing) begin
            state_d.clr_pend = 1'b1;
        end

        unique case (state_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (cfg_enable && !lk_hit) begin
                        state_d.st      = ST_FETCH;
                        state_d.pend_va = req_vaddr;
                        state_d.pend_wr = req_write;
                    end
                end else if (state_q.clr_pend) begin
                    state_d.st       = ST_CLEAR;
                    state_d.clr_pend = 1'b0;
                    state_d.clr_idx  = '0;
                end
            end
            ST_FETCH: begin
                if (mem_rd_ack) state_d.st = ST_IDLE;
            end
            ST_CLEAR: begin
                if (state_q.clr_idx == IDX_W'(TLB_N-1)) state_d.st = ST_IDLE;
                else state_d.clr_idx = state_q.clr_idx + 1'b1;
            end
            default: state_d.st = ST_IDLE;
        endcase

        if (do_rsp) begin
            state_d.rsp_v     = 1'b1;
            state_d.rsp_pa    = ev_pa;
            state_d.rsp_fault = ev_fault;
            state_d.rsp_abort = ev_abort;
        end

        if (fault_clr) begin
            state_d.flt_v = 1'b0;
            state_d.irq   = 1'b0;
        end
        if (do_rsp && ev_fault) begin
            if (!state_q.flt_v || fault_clr) begin
                state_d.flt_v  = 1'b1;
                state_d.flt_va = sel_va;
                state_d.flt_ty = ev_type;
            end
            if (ev_irq) state_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid   = state_q.rsp_v;
    assign rsp_paddr   = state_q.rsp_pa;
    assign rsp_fault   = state_q.rsp_fault;
    assign rsp_abort   = state_q.rsp_abort;
    assign fault_valid = state_q.flt_v;
    assign fault_vaddr = state_q.flt_va;
    assign fault_type  = state_q.flt_ty;
    assign irq         = state_q.irq;

    a_r11_no_accept_while_clearing: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_clearing |-> !req_ready);

    a_r12_one_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);

    a_r2_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    a_r6_abort_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abort) |-> (rsp_fault && rsp_paddr == '0));

    a_r9_record_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !fault_clr) |=> (fault_valid && $stable(fault_vaddr) && $stable(fault_type)));

    a_r10_irq_has_record: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fault_valid);
endmodule

// File: tb/ptmmu_top_tb_top.sv
`timescale 1ns/1ps
module ptmmu_top_tb_top;
    localparam int TLB_N = 8;
    localparam logic [23:0] PT_BASE = 24'h012345;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 0, req_ready, req_write = 0;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid, rsp_fault, rsp_abort;
    logic [35:0] rsp_paddr;
    logic        mem_rd_req, mem_rd_ack = 0;
    logic [35:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        cfg_enable = 0, cfg_inv_en = 0, cfg_inv_abort = 0, cfg_inv_irq = 0;
    logic        cfg_wv_en = 0, cfg_wv_abort = 0, cfg_wv_irq = 0, cfg_scratch_en = 0;
    logic [23:0] cfg_pt_base = PT_BASE, cfg_scratch_ppn = 24'h0ABCDE;
    logic        tlb_clear = 0, tlb_clearing, fault_valid, fault_clr = 0, irq;
    logic [31:0] fault_vaddr;
    logic [1:0]  fault_type;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    ptmmu_top dut_i (.*);

    // ---------------- bench models ----------------
    logic [19:0] m_tag [TLB_N];
    bit          m_sup [TLB_N];
    bit          m_vld [TLB_N];
    int          m_rr = 0;
    bit          m_fv = 0, m_irq = 0;
    logic [31:0] m_fva = '0;
    logic [1:0]  m_fty = '0;

    // descriptor layout: 31 super, 29 writeable, 28 valid, 23:0 page number
    function automatic logic [31:0] tbl_entry(logic [19:0] vpn);
        logic [31:0] h;
        h = {12'b0, vpn} * 32'h9E3779B1;
        h = h ^ (h >> 13);
        case (vpn[19:8])
            12'h0A5: return {4'b1011, 4'h0, 16'h3C5A, vpn[7:0]};
            12'h001: return {4'b0011, 4'h0, 4'h5, vpn};
            12'h002: return {4'b0001, 4'h0, 4'h6, vpn};
            12'h003: return 32'h0;
            default: return {2'b00, h[30], h[29] | h[28], 4'h0, h[23:0]};
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic model_access(input logic [19:0] vpn, output bit hit);
        logic [31:0] e;
        hit = 0;
        for (int i = 0; i < TLB_N; i++)
            if (m_vld[i] && (m_sup[i] ? (m_tag[i][19:8] == vpn[19:8]) : (m_tag[i] == vpn))) hit = 1;
        e = tbl_entry(vpn);
        if (!hit && e[28]) begin
            m_vld[m_rr] = 1; m_tag[m_rr] = vpn; m_sup[m_rr] = e[31];
            m_rr = (m_rr + 1) % TLB_N;
        end
    endtask

    // memory responder: ack two cycles after a request appears
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rd_ack) mem_rd_ack = 0;
            else if (mem_rd_req) begin
                cnt++;
                if (cnt == 2) begin
                    logic [35:0] off;
                    off = mem_rd_addr - {cfg_pt_base, 12'h000};
                    mem_rd_data = tbl_entry(off[21:2]);
                    mem_rd_ack = 1;
                    cnt = 0;
                end
            end
        end
    end

    task automatic do_req(input logic [31:0] va, input logic wr, input string rq);
        logic [31:0] e;
        logic [19:0] vpn;
        logic [23:0] eff;
        logic [35:0] exp_pa, got_addr;
        bit exp_fault, exp_abort, raise, hit, exp_fetch, got_fetch, ready_seen;
        logic [1:0] ty;
        int cyc;
        vpn = va[31:12];
        e = tbl_entry(vpn);
        eff = e[31] ? {e[23:8], vpn[7:0]} : e[23:0];
        exp_fault = 0; exp_abort = 0; raise = 0; ty = 0;
        if (!cfg_enable) begin
            exp_pa = {4'h0, va}; exp_fetch = 0;
        end else begin
            model_access(vpn, hit);
            exp_fetch = !hit;
            if (!e[28] && cfg_inv_en) begin
                exp_fault = 1; exp_abort = cfg_inv_abort; raise = cfg_inv_irq; ty = 2'b01;
            end else if (e[28] && wr && !e[29] && cfg_wv_en) begin
                exp_fault = 1; exp_abort = cfg_wv_abort; raise = cfg_wv_irq; ty = 2'b10;
            end
            if (exp_abort) exp_pa = '0;
            else if (exp_fault && cfg_scratch_en) exp_pa = {cfg_scratch_ppn, va[11:0]};
            else exp_pa = {eff, va[11:0]};
        end
        if (exp_fault) begin
            if (!m_fv) begin m_fv = 1; m_fva = va; m_fty = ty; end
            if (raise) m_irq = 1;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 0;
        got_fetch = 0; got_addr = '0; ready_seen = 0; cyc = 0;
        while (!rsp_valid && cyc < 50) begin
            if (mem_rd_req) begin
                got_fetch = 1; got_addr = mem_rd_addr;
                if (req_ready) ready_seen = 1;
            end
            @(negedge clk);
            cyc++;
        end
        chk(rq, "rsp_valid", rsp_valid, 1);
        chk(rq, "paddr", rsp_paddr, exp_pa);
        chk(rq, "fault", rsp_fault, exp_fault);
        chk(rq, "abort", rsp_abort, exp_abort);
        chk(rq, "table read made", got_fetch, exp_fetch);
        if (exp_fetch) begin
            chk("R2", "table address", got_addr, {PT_BASE, 12'h000} + {14'h0, vpn, 2'b00});
            chk("R12", "ready during fetch", ready_seen, 0);
        end
        chk("R9", "fault_valid", fault_valid, m_fv);
        if (m_fv) begin
            chk("R9", "fault_vaddr", fault_vaddr, m_fva);
            chk("R9", "fault_type", fault_type, m_fty);
        end
        chk("R10", "irq", irq, m_irq);
    endtask

    task automatic pulse_fault_clr();
        @(negedge clk);
        fault_clr = 1;
        @(negedge clk);
        fault_clr = 0;
        m_fv = 0; m_irq = 0;
        chk("R9", "record cleared", fault_valid, 0);
        chk("R10", "irq cleared", irq, 0);
    endtask

    task automatic do_flush(input bit second_pulse);
        int cnt;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        tlb_clear = 1;
        @(negedge clk);
        tlb_clear = second_pulse;
        chk("R11", "clearing after pulse", tlb_clearing, 1);
        chk("R11", "ready low while clearing", req_ready, 0);
        cnt = 1;
        @(negedge clk);
        tlb_clear = 0;
        while (tlb_clearing && cnt < 100) begin cnt++; @(negedge clk); end
        chk("R11", "clearing length", cnt, TLB_N + 1);
        for (int i = 0; i < TLB_N; i++) m_vld[i] = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < TLB_N; i++) begin m_vld[i] = 0; m_sup[i] = 0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R12", "reset ready", req_ready, 1);
        chk("R11", "reset clearing", tlb_clearing, 0);
        chk("R9", "reset record", fault_valid, 0);
        chk("R10", "reset irq", irq, 0);
        chk("R2", "reset table read", mem_rd_req, 0);

        // R1 pass-through with faults armed
        cfg_inv_en = 1; cfg_inv_abort = 1; cfg_wv_en = 1;
        do_req(32'h0030_0ABC, 1, "R1");
        do_req(32'hFFFF_F123, 0, "R1");

        // R2 / R3 translation then hit
        cfg_enable = 1; cfg_inv_en = 0; cfg_inv_abort = 0; cfg_wv_en = 0;
        do_req(32'h0010_4567, 0, "R2");
        do_req(32'h0010_4FF0, 1, "R3");

        // R4 rotation after a flush
        do_flush(0);
        for (int p = 0; p < 9; p++) do_req({12'h001, p[7:0], 12'h010}, 0, "R4");
        do_req(32'h0010_0020, 0, "R4");
        do_req(32'h0010_2030, 0, "R4");

        // R5 superpage
        do_flush(0);
        do_req(32'h0A51_0123, 1, "R5");
        do_req(32'h0A5F_7456, 0, "R5");

        // R6 invalid descriptor
        cfg_inv_en = 1; cfg_inv_abort = 1;
        do_req(32'h0030_0111, 0, "R6");
        do_req(32'h0030_0222, 0, "R6");
        pulse_fault_clr();
        cfg_inv_en = 0;
        do_req(32'h0030_1333, 1, "R6");

        // R7 write violation, R8 scratch
        cfg_wv_en = 1; cfg_wv_abort = 0; cfg_scratch_en = 0;
        do_req(32'h0020_0444, 1, "R7");
        do_req(32'h0020_0555, 0, "R7");
        pulse_fault_clr();
        cfg_scratch_en = 1;
        do_req(32'h0020_1666, 1, "R8");
        cfg_inv_en = 1; cfg_inv_abort = 0;
        do_req(32'h0030_2777, 0, "R8");
        pulse_fault_clr();
        cfg_scratch_en = 0;

        // R9 sticky record, R10 interrupt
        cfg_inv_irq = 0; cfg_wv_irq = 1;
        do_req(32'h0030_3888, 0, "R9");
        do_req(32'h0020_2999, 1, "R10");
        pulse_fault_clr();
        do_req(32'h0020_2AAA, 1, "R9");
        pulse_fault_clr();

        // R11 ignored second pulse
        do_flush(1);
        do_req(32'h0010_4123, 0, "R11");

        // random phase
        for (int it = 0; it < 500; it++) begin
            logic [31:0] va;
            int sel;
            if (it % 25 == 0) begin
                cfg_enable     = ($urandom % 8) != 0;
                cfg_inv_en     = $urandom % 2; cfg_inv_abort = $urandom % 2; cfg_inv_irq = $urandom % 2;
                cfg_wv_en      = $urandom % 2; cfg_wv_abort  = $urandom % 2; cfg_wv_irq  = $urandom % 2;
                cfg_scratch_en = $urandom % 2; cfg_scratch_ppn = 24'($urandom);
            end
            if ($urandom % 40 == 0) pulse_fault_clr();
            if ($urandom % 60 == 0) do_flush($urandom % 2);
            sel = $urandom % 5;
            case (sel)
                0: va = {12'h001, 8'($urandom % 4), 12'($urandom)};
                1: va = {12'h002, 8'($urandom % 3), 12'($urandom)};
                2: va = {12'h003, 8'($urandom % 2), 12'($urandom)};
                3: va = {12'h0A5, 8'($urandom), 12'($urandom)};
                default: va = {12'h004, 8'($urandom % 6), 12'($urandom)};
            endcase
            do_req(va, $urandom % 2, "R3");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule